// File: doc/BRIEF.md
# Initiator Attribute Mapper with Coherency Routing

This block sits between a set of bus initiators and the interconnect. Every initiator has two request ports, one for reads and one for writes, and each port owns a 32-bit attribute register. When a request is accepted, the block stamps it with that port's register contents: address type, virtual ID, priority, address selector, order ID and QoS. It then decides where the request goes. The selector sends the request either to the ordinary non-coherent system path or to a cache-coherency port. It also sets a cache-allocate hint, which depends on both the selector value and the direction of the request.

Software programs the registers through a single-cycle register interface. Each access gets one response cycle, and an access to an unmapped offset returns an error. A sticky status word records every port that issued a request with an illegal selector value. Requests pass through a one-entry output register with a valid/ready handshake. Port numbering is fixed: port `2*i` is the read port of initiator `i` and port `2*i+1` is its write port.

Top module: `attr_route_mapper`

## Requirements
- R1: After reset, every port register reads 0x00007000, the status word at offset 0x000 reads 0, `out_valid` is 0 and `req_ready` is 1.
- R2: In a port register, bits 31:30, 15 and 3 always read as zero and ignore written values. All other bits read back exactly as written. The field layout is: address type 29:28, virtual ID 27:16, priority 14:12, selector 11:8, order ID 7:4, QoS 2:0.
- R3: The register of port N is at byte offset N*0x400 + 0x100. Port 2i is the read port of initiator i and port 2i+1 is its write port. A write to one port register leaves every other port register unchanged.
- R4: A register access to any other offset, or to a port register beyond the last port, gives `rsp_err`=1 and `rsp_rdata`=0 in its response cycle. If the access is a write, it changes no state. Every access is answered with `rsp_valid` one cycle after `reg_en`.
- R5: A request whose selector is 0 leaves with `out_coh`=0 (non-coherent system path) and `out_alloc`=0.
- R6: A write-port request with selector 14 leaves with `out_coh`=1 and `out_alloc`=1. A write-port request with selector 15 leaves with `out_coh`=1 and `out_alloc`=0.
- R7: A read-port request with selector 14 or 15 leaves with `out_coh`=1 and `out_alloc`=0.
- R8: A request with any selector other than 0, 14 or 15 leaves with `out_coh`=0 and `out_alloc`=0. It also sets bit N of the status word, where N is the issuing port. The bit stays set until software writes 1 to it. If a new illegal request on port N and a clearing write to bit N happen in the same cycle, the bit ends up set.
- R9: An accepted request appears on the outputs one cycle after acceptance. It carries its own port, address and direction, together with the address type, virtual ID, priority, selector, order ID and QoS of its port register.
- R10: A request accepted in the same cycle as a register write to its port carries the old register contents. A request accepted in any later cycle carries the new contents.
- R11: `req_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output field stays unchanged, and so do later register writes and waiting requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data; for the status word, 1 bits clear |
| rsp_valid | output | 1 | Response cycle of an access |
| rsp_rdata | output | 32 | Read data (0 on error) |
| rsp_err | output | 1 | Access hit an unmapped offset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_port | input | PORT_W | Issuing port; LSB 1 means write |
| req_addr | input | REQ_ADDR_W | Request address |
| out_valid | output | 1 | Stamped request present |
| out_ready | input | 1 | Downstream takes the stamped request |
| out_port | output | PORT_W | Issuing port |
| out_addr | output | REQ_ADDR_W | Request address |
| out_write | output | 1 | 1 for a write-port request |
| out_coh | output | 1 | 1 = coherency port, 0 = system path |
| out_alloc | output | 1 | Cache-allocate hint |
| out_atype | output | 2 | 0 physical, 1 intermediate, 2 virtual, 3 physical coherent |
| out_vid | output | 12 | Virtual ID |
| out_prio | output | 3 | Priority |
| out_sel | output | 4 | Address selector |
| out_oid | output | 4 | Order ID |
| out_qos | output | 3 | QoS |

## Verification
Two pairs of functions can meet in one cycle, and the bench forces both at the same falling edge. In the first pair, a register write to a port coincides with the acceptance of a request on that same port. The bench checks that this request still shows the old selector's route and allocate hint, while the next request shows the new ones. In the second pair, an illegal-selector request on a port coincides with a write that clears the status bit of that port. A read-back of the status word must then show the bit still set. Before these, every selector value is swept over every port, and the route, hint, fields and status are compared with values computed in the bench.

// File: rtl/iam_pkg.sv
package iam_pkg;

    localparam int          WORD_W     = 32;
    localparam logic [31:0] ATTR_RESET = 32'h0000_7000;
    localparam logic [31:0] ATTR_WMASK = 32'h3FFF_7FF7;
    localparam int          SLOT_SHIFT = 10;
    localparam logic [9:0]  SLOT_OFS   = 10'h100;

    localparam logic [3:0] SEL_SYS         = 4'd0;
    localparam logic [3:0] SEL_COH_ALLOC   = 4'd14;
    localparam logic [3:0] SEL_COH_NOALLOC = 4'd15;

    typedef enum logic [1:0] {
        AT_PHYS     = 2'd0,
        AT_INTER    = 2'd1,
        AT_VIRT     = 2'd2,
        AT_PHYS_COH = 2'd3
    } addr_type_e;

    typedef enum logic {
        ROUTE_SYS = 1'b0,
        ROUTE_COH = 1'b1
    } route_e;

    typedef struct packed {
        addr_type_e  atype;
        logic [11:0] vid;
        logic [2:0]  prio;
        logic [3:0]  sel;
        logic [3:0]  oid;
        logic [2:0]  qos;
    } attr_t;

    typedef struct packed {
        route_e route;
        logic   alloc;
        logic   illegal;
    } steer_t;

    function automatic attr_t word_to_attr(input logic [31:0] w);
        attr_t a;
        a.atype = addr_type_e'(w[29:28]);
        a.vid   = w[27:16];
        a.prio  = w[14:12];
        a.sel   = w[11:8];
        a.oid   = w[7:4];
        a.qos   = w[2:0];
        return a;
    endfunction

    function automatic steer_t decide(input logic [3:0] sel, input logic is_wr);
        steer_t s;
        s.route   = ROUTE_SYS;
        s.alloc   = 1'b0;
        s.illegal = 1'b0;
        unique case (sel)
            SEL_SYS: ;
            SEL_COH_ALLOC: begin
                s.route = ROUTE_COH;
                s.alloc = is_wr;
            end
            SEL_COH_NOALLOC: s.route = ROUTE_COH;
            default: s.illegal = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/iam_regbank.sv
module iam_regbank
    import iam_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 16,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    input  logic [NUM_PORTS-1:0] err_set,
    output logic [NUM_PORTS-1:0] stat_o,
    output attr_t [NUM_PORTS-1:0] attr_o
);

    localparam int IDX_W = ADDR_W - SLOT_SHIFT;

    logic [IDX_W-1:0]     slot;
    logic                 hit_port;
    logic                 hit_stat;
    logic [PORT_W-1:0]    pidx;
    logic [WORD_W-1:0]    words [NUM_PORTS];
    logic [NUM_PORTS-1:0] stat_q;
    logic [NUM_PORTS-1:0] clr;
    logic [WORD_W-1:0]    rdata_c;
    logic                 rsp_was_port;

    always_comb begin
        slot     = reg_addr[ADDR_W-1:SLOT_SHIFT];
        hit_port = (reg_addr[SLOT_SHIFT-1:0] == SLOT_OFS) && (slot < IDX_W'(NUM_PORTS));
        hit_stat = (reg_addr == '0);
        pidx     = slot[PORT_W-1:0];
        clr      = (reg_en && reg_we && hit_stat) ? reg_wdata[NUM_PORTS-1:0] : '0;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= ATTR_RESET;
            end else if (reg_en && reg_we && hit_port && pidx == PORT_W'(g)) begin
                words[g] <= reg_wdata & ATTR_WMASK;
            end
        end
        assign attr_o[g] = word_to_attr(words[g]);

        // R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (stat_q[g] && !clr[g]) |=> stat_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | err_set;
    end
    assign stat_o = stat_q;

    always_comb begin
        rdata_c = '0;
        if (hit_port)      rdata_c = words[pidx];
        else if (hit_stat) rdata_c = WORD_W'(stat_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_err      <= 1'b0;
            rsp_was_port <= 1'b0;
        end else begin
            rsp_valid    <= reg_en;
            rsp_rdata    <= reg_en ? rdata_c : '0;
            rsp_err      <= reg_en && !hit_port && !hit_stat;
            rsp_was_port <= reg_en && hit_port;
        end
    end

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R4
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        reg_en |=> rsp_valid);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_was_port) |-> ((rsp_rdata & ~ATTR_WMASK) == '0));

endmodule

// File: rtl/iam_slice.sv
module iam_slice
    import iam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PORT_W-1:0] in_port,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  attr_t             in_attr,
    input  steer_t            in_steer,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PORT_W-1:0] out_port,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output attr_t             out_attr,
    output steer_t            out_steer
);

    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_addr  <= '0;
            out_write <= 1'b0;
            out_attr  <= word_to_attr(ATTR_RESET);
            out_steer <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_port  <= in_port;
                out_addr  <= in_addr;
                out_write <= in_write;
                out_attr  <= in_attr;
                out_steer <= in_steer;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_port)
            && $stable(out_attr) && $stable(out_steer) && $stable(out_write)));

    // R6
    alloc_write_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_steer.alloc) |-> (out_steer.route == ROUTE_COH && out_write
            && out_attr.sel == SEL_COH_ALLOC));

    // R5
    coh_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_steer.route == ROUTE_COH) |-> (out_attr.sel[3:1] == 3'b111));

endmodule

// File: rtl/attr_route_mapper.sv
module attr_route_mapper
    import iam_pkg::*;
#(
    parameter int NUM_INIT   = 2,
    parameter int REQ_ADDR_W = 32,
    parameter int REG_ADDR_W = 16,
    localparam int NUM_PORTS = 2 * NUM_INIT,
    localparam int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_err,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [PORT_W-1:0]     req_port,
    input  logic [REQ_ADDR_W-1:0] req_addr,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PORT_W-1:0]     out_port,
    output logic [REQ_ADDR_W-1:0] out_addr,
    output logic                  out_write,
    output logic                  out_coh,
    output logic                  out_alloc,
    output logic [1:0]            out_atype,
    output logic [11:0]           out_vid,
    output logic [2:0]            out_prio,
    output logic [3:0]            out_sel,
    output logic [3:0]            out_oid,
    output logic [2:0]            out_qos
);

    attr_t [NUM_PORTS-1:0] attr_bank;
    logic  [NUM_PORTS-1:0] stat;
    logic  [NUM_PORTS-1:0] err_set;
    attr_t                 cur_attr;
    steer_t                cur_steer;
    logic                  is_wr;
    logic                  accept;
    attr_t                 o_attr;
    steer_t                o_steer;

    iam_regbank #(
        .NUM_PORTS(NUM_PORTS),
        .ADDR_W   (REG_ADDR_W),
        .PORT_W   (PORT_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err),
        .err_set  (err_set),
        .stat_o   (stat),
        .attr_o   (attr_bank)
    );

    always_comb begin
        cur_attr = word_to_attr(ATTR_RESET);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_port == PORT_W'(p)) cur_attr = attr_bank[p];
        end
        is_wr     = req_port[0];
        cur_steer = decide(cur_attr.sel, is_wr);
        accept    = req_valid && req_ready;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_err
        assign err_set[g] = accept && cur_steer.illegal && (req_port == PORT_W'(g));
    end

    iam_slice #(
        .ADDR_W(REQ_ADDR_W),
        .PORT_W(PORT_W)
    ) u_slice (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_port  (req_port),
        .in_addr  (req_addr),
        .in_write (is_wr),
        .in_attr  (cur_attr),
        .in_steer (cur_steer),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_port (out_port),
        .out_addr (out_addr),
        .out_write(out_write),
        .out_attr (o_attr),
        .out_steer(o_steer)
    );

    assign out_coh   = (o_steer.route == ROUTE_COH);
    assign out_alloc = o_steer.alloc;
    assign out_atype = o_attr.atype;
    assign out_vid   = o_attr.vid;
    assign out_prio  = o_attr.prio;
    assign out_sel   = o_attr.sel;
    assign out_oid   = o_attr.oid;
    assign out_qos   = o_attr.qos;

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cur_steer.illegal) |=> stat[$past(req_port)]);

    // R8
    illegal_route_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o_steer.illegal) |-> (!out_coh && !out_alloc));

    // R7
    read_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_write) |-> !out_alloc);

endmodule

// File: tb/attr_route_mapper_bench.sv
module attr_route_mapper_bench;

    localparam int NI = 2;
    localparam int NP = 2 * NI;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_port = '0;
    logic [31:0] req_addr = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [1:0]  out_port;
    logic [31:0] out_addr;
    logic        out_write, out_coh, out_alloc;
    logic [1:0]  out_atype;
    logic [11:0] out_vid;
    logic [2:0]  out_prio, out_qos;
    logic [3:0]  out_sel, out_oid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    attr_route_mapper #(.NUM_INIT(NI), .REQ_ADDR_W(32), .REG_ADDR_W(16)) u_attr_route_mapper (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port), .req_addr(req_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port), .out_addr(out_addr),
        .out_write(out_write), .out_coh(out_coh), .out_alloc(out_alloc), .out_atype(out_atype),
        .out_vid(out_vid), .out_prio(out_prio), .out_sel(out_sel), .out_oid(out_oid),
        .out_qos(out_qos)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_acc(input logic we, input logic [15:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output logic er, output logic vl);
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
    endtask

    task automatic send(input logic [1:0] p, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_port = p; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [15:0] port_ofs(input int p);
        return 16'(p * 16'h400 + 16'h100);
    endfunction

    function automatic logic [1:0] exp_route(input logic [3:0] s, input logic wr);
        // {coh, alloc}
        if (s == 4'd14) return {1'b1, wr};
        if (s == 4'd15) return 2'b10;
        return 2'b00;
    endfunction

    logic [31:0] rd;
    logic        er, vl;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        for (int p = 0; p < NP; p++) begin
            reg_acc(1'b0, port_ofs(p), '0, rd, er, vl);
            chk(rd == 32'h0000_7000 && !er && vl, "R1 port reset", 64'({vl, er, rd}), 64'({2'b10, 32'h7000}));
        end
        reg_acc(1'b0, 16'h0000, '0, rd, er, vl);
        chk(rd == 32'h0 && !er, "R1 status reset", 64'(rd), 64'd0);

        // R4 unmapped offsets
        reg_acc(1'b0, 16'h0104, '0, rd, er, vl);
        chk(er && rd == 0 && vl, "R4 off-slot read", 64'({vl, er, rd}), 64'({2'b11, 32'h0}));
        reg_acc(1'b0, port_ofs(NP), '0, rd, er, vl);
        chk(er && rd == 0, "R4 beyond last port", 64'({er, rd}), 64'({1'b1, 32'h0}));
        reg_acc(1'b1, 16'h0504, 32'hFFFF_FFFF, rd, er, vl);
        chk(er, "R4 unmapped write err", 64'(er), 64'd1);
        for (int p = 0; p < NP; p++) begin
            reg_acc(1'b0, port_ofs(p), '0, rd, er, vl);
            chk(rd == 32'h0000_7000, "R4 write had no effect", 64'(rd), 64'h7000);
        end

        // R2 reserved bits
        reg_acc(1'b1, port_ofs(2), 32'hFFFF_FFFF, rd, er, vl);
        reg_acc(1'b0, port_ofs(2), '0, rd, er, vl);
        chk(rd == 32'h3FFF_7FF7, "R2 all-ones readback", 64'(rd), 64'h3FFF7FF7);
        // R3 neighbours untouched
        reg_acc(1'b0, port_ofs(1), '0, rd, er, vl);
        chk(rd == 32'h0000_7000, "R3 neighbour untouched", 64'(rd), 64'h7000);
        reg_acc(1'b0, port_ofs(3), '0, rd, er, vl);
        chk(rd == 32'h0000_7000, "R3 neighbour untouched", 64'(rd), 64'h7000);

        // Sweep: all ports x all selectors (R3 R5 R6 R7 R8 R9)
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 16; s++) begin
                logic [1:0]  at;
                logic [11:0] vid;
                logic [2:0]  pr, qs;
                logic [3:0]  sl, od;
                logic [31:0] w, a;
                logic [1:0]  er2;
                logic        wr;
                at  = 2'((p + s) % 4);
                vid = 12'((p * 37 + s * 101) & 12'hfff);
                pr  = 3'(s % 8);
                sl  = 4'(s);
                od  = 4'(15 - s);
                qs  = 3'((p + s + 1) % 8);
                w   = {2'b00, at, vid, 1'b0, pr, sl, od, 1'b0, qs};
                a   = 32'h1000_0000 + 32'(p * 256 + s * 4);
                wr  = p[0];
                reg_acc(1'b1, port_ofs(p), w | (s[0] ? 32'hC000_8008 : 32'h0), rd, er, vl);
                reg_acc(1'b0, port_ofs(p), '0, rd, er, vl);
                chk(rd == w && !er, "R2 R3 field readback", 64'(rd), 64'(w));
                send(2'(p), a);
                chk(out_valid && out_port == 2'(p) && out_addr == a && out_write == wr,
                    "R9 request identity", 64'({out_valid, out_write, out_port, out_addr}),
                    64'({1'b1, wr, 2'(p), a}));
                chk({out_atype, out_vid, out_prio, out_sel, out_oid, out_qos} == {at, vid, pr, sl, od, qs},
                    "R9 stamped fields", 64'({out_atype, out_vid, out_prio, out_sel, out_oid, out_qos}),
                    64'({at, vid, pr, sl, od, qs}));
                er2 = exp_route(sl, wr);
                if (s == 0)
                    chk({out_coh, out_alloc} == er2, "R5 system route", 64'({out_coh, out_alloc}), 64'(er2));
                else if (s >= 14 && wr)
                    chk({out_coh, out_alloc} == er2, "R6 coherent write", 64'({out_coh, out_alloc}), 64'(er2));
                else if (s >= 14)
                    chk({out_coh, out_alloc} == er2, "R7 coherent read", 64'({out_coh, out_alloc}), 64'(er2));
                else
                    chk({out_coh, out_alloc} == er2, "R8 illegal route", 64'({out_coh, out_alloc}), 64'(er2));
                reg_acc(1'b0, 16'h0000, '0, rd, er, vl);
                if (s != 0 && s < 14) begin
                    chk(rd == 32'(1 << p), "R8 sticky set", 64'(rd), 64'(1 << p));
                    reg_acc(1'b1, 16'h0000, 32'(1 << p), rd, er, vl);
                    reg_acc(1'b0, 16'h0000, '0, rd, er, vl);
                    chk(rd == 32'h0, "R8 write-one clear", 64'(rd), 64'd0);
                end else begin
                    chk(rd == 32'h0, "R8 no flag on legal selector", 64'(rd), 64'd0);
                end
            end
        end

        // R10: register write and request on the same port in the same cycle
        reg_acc(1'b1, port_ofs(1), 32'h0000_0E00, rd, er, vl);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = port_ofs(1); reg_wdata = 32'h0000_0F00;
        req_valid = 1'b1; req_port = 2'd1; req_addr = 32'hABCD_0000;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; req_valid = 1'b0;
        chk(out_valid && out_sel == 4'd14 && out_alloc == 1'b1, "R10 old attributes kept",
            64'({out_valid, out_sel, out_alloc}), 64'({1'b1, 4'd14, 1'b1}));
        send(2'd1, 32'hABCD_0004);
        chk(out_sel == 4'd15 && out_coh && !out_alloc, "R10 new attributes next",
            64'({out_sel, out_coh, out_alloc}), 64'({4'd15, 2'b10}));

        // R11: stall holds the stamped request
        reg_acc(1'b1, port_ofs(2), 32'h1234_5E67, rd, er, vl);
        out_ready = 1'b0;
        send(2'd2, 32'h5555_0000);
        begin
            logic [63:0] snap;
            snap = {out_addr, out_port, out_sel, out_vid, out_coh, out_alloc, out_write, out_atype, out_qos};
            @(negedge clk);
            reg_en = 1'b1; reg_we = 1'b1; reg_addr = port_ofs(2); reg_wdata = 32'h0000_0000;
            req_valid = 1'b1; req_port = 2'd3; req_addr = 32'h6666_0000;
            @(negedge clk);
            reg_en = 1'b0; reg_we = 1'b0;
            repeat (2) @(negedge clk);
            chk(req_ready == 1'b0, "R11 ready low under stall", 64'(req_ready), 64'd0);
            chk(out_valid && {out_addr, out_port, out_sel, out_vid, out_coh, out_alloc, out_write, out_atype, out_qos} == snap,
                "R11 outputs held", {out_addr, out_port, out_sel, out_vid, out_coh, out_alloc, out_write, out_atype, out_qos}, snap);
        end
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid && out_port == 2'd3 && out_addr == 32'h6666_0000, "R11 waiting request taken",
            64'({out_valid, out_port, out_addr}), 64'({1'b1, 2'd3, 32'h6666_0000}));

        // R8: new illegal request and clearing write in the same cycle
        reg_acc(1'b1, port_ofs(0), 32'h0000_0500, rd, er, vl);
        send(2'd0, 32'h0);
        reg_acc(1'b0, 16'h0000, '0, rd, er, vl);
        chk(rd == 32'h1, "R8 flag before race", 64'(rd), 64'd1);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 16'h0000; reg_wdata = 32'h1;
        req_valid = 1'b1; req_port = 2'd0; req_addr = 32'h40;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; req_valid = 1'b0;
        reg_acc(1'b0, 16'h0000, '0, rd, er, vl);
        chk(rd == 32'h1, "R8 set wins over clear", 64'(rd), 64'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule